// File: doc/BRIEF.md
# Multi-rate TDM time-slot interchange

This block is a non-blocking time-slot interchange for a bank of serial TDM lanes. There are 16 input lanes and 16 output lanes by default. A frame pulse at 8 kHz marks the frame boundary. A two-bit rate selector sets the lane bit rate, and with it the number of 8-bit channels in each frame: the base count, twice the base count, or four times the base count. The master clock always runs at twice the lane bit rate, so one bit is taken on every second clock edge.

Incoming bytes are stored in their natural order in a two-bank data memory. One bank fills with the current frame while the other bank, which holds the previous frame, is read out. A connection memory is loaded through a small write port. It names, for every output lane and channel, the input lane and channel whose byte is sent there. A per-input bit offset shifts that lane's channel boundaries, which lets lanes that arrive with different delays be realigned.

The timing controller is a three-state machine:
- `S_HUNT`: waiting for the first frame pulse after reset.
- `S_BIT`: the next edge samples a bit.
- `S_GAP`: the next edge is the idle half of a bit period.

A frame pulse moves any state to `S_BIT`. Without a pulse, `S_BIT` goes to `S_GAP`, `S_GAP` goes to `S_BIT`, and `S_HUNT` stays in `S_HUNT`.

Top module: `tsi_switch`

## Requirements
- R1: After reset, and until the first frame pulse, every output lane is held high.
- R2: The clock edge that samples the frame pulse clears the bit position. Input bit j of a frame is sampled on edge 2j+1 after that edge, most significant bit first. Output bit j is presented from that same edge until the next sampling edge.
- R3: With rate_sel = 00, a frame holds BASE_CH channels (32 by default) on each lane, which is 8*BASE_CH bits.
- R4: With rate_sel = 01, a frame holds 2*BASE_CH channels (64 by default) on each lane.
- R5: With rate_sel = 10, a frame holds 4*BASE_CH channels (128 by default) on each lane.
- R6: rate_sel = 11 behaves exactly as 00.
- R7: A write with cfg_sel = 0 sets the entry for output lane cfg_addr[upper ST_W bits] and channel cfg_addr[low CH_W bits]. The source channel is taken from cfg_wdata[CH_W-1:0] (7 bits by default), and the source lane from the next ST_W bits (4 by default). That output channel then carries the byte of the chosen source.
- R8: An output channel whose entry has not been written since reset sends 8'hFF.
- R9: An entry whose source channel is not below the active channel count sends 8'hFF.
- R10: A write with cfg_sel = 1 sets the bit offset of input lane cfg_addr[upper ST_W bits] to cfg_wdata[POS_W-1:0], taken modulo the frame length. Input channel c of that lane is then the 8 bits starting at frame bit (8c + offset) mod frame length.
- R11: The output in frame N+1 carries the input bytes of frame N. A change in input content first shows up one frame after it arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, twice the lane bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_pulse | input | 1 | One-cycle frame start marker |
| rate_sel | input | 2 | Lane rate and channel count selector |
| ser_in | input | NSTREAM | Serial input lanes |
| ser_out | output | NSTREAM | Serial output lanes |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = connection entry, 1 = lane offset |
| cfg_addr | input | log2(NSTREAM)+log2(4*BASE_CH) | {lane, channel} address |
| cfg_wdata | input | 16 | Connection entry or offset value |

BASE_CH and NSTREAM must be powers of two.

## Verification
The bench runs a reduced configuration: 4 lanes and a base of 4 channels. Each input byte is a distinct arithmetic function of lane, channel and a content tag, so a wrong lane, a wrong channel or a wrong frame each gives a different wrong byte. The mapping is a skewed permutation that mixes lanes and channels. It deliberately leaves one entry unwritten and points another past the active count, so the idle paths can be told apart from real data.

The same mapping is run in all four rate codes, with both zero and non-zero offsets, where one offset exceeds the frame length and gets wrapped. A content-tag change checked in the very next frame separates correct double buffering from a read of the bank currently being written.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

    typedef enum logic [1:0] {
        S_HUNT = 2'd0,
        S_GAP  = 2'd1,
        S_BIT  = 2'd2
    } tsi_state_e;

    localparam logic [1:0] RATE_X1 = 2'b00;
    localparam logic [1:0] RATE_X2 = 2'b01;
    localparam logic [1:0] RATE_X4 = 2'b10;

endpackage

// File: rtl/tsi_timing.sv
module tsi_timing
    import tsi_pkg::*;
#(
    parameter int BASE_CH = 32,
    parameter int CH_W    = 7,
    parameter int POS_W   = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_pulse,
    input  logic [1:0]       rate_sel,
    output logic             strobe,
    output logic             synced,
    output logic             wbank,
    output logic [POS_W-1:0] pos,
    output logic [POS_W-1:0] pos_mask,
    output logic [CH_W:0]    act_ch
);
    localparam int ACT_W = CH_W + 1;

    tsi_state_e state_q, state_d;

    // active channel count per rate code; code 11 falls back to base rate
    always_comb begin
        unique case (rate_sel)
            RATE_X2: act_ch = ACT_W'(BASE_CH * 2);
            RATE_X4: act_ch = ACT_W'(BASE_CH * 4);
            default: act_ch = ACT_W'(BASE_CH);
        endcase
    end

    assign pos_mask = {act_ch[CH_W-1:0], 3'b000} - 1'b1;

    always_comb begin
        state_d = state_q;
        if (frame_pulse) begin
            state_d = S_BIT;
        end else begin
            unique case (state_q)
                S_HUNT:  state_d = S_HUNT;
                S_GAP:   state_d = S_BIT;
                S_BIT:   state_d = S_GAP;
                default: state_d = S_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_HUNT;
        else        state_q <= state_d;
    end

    always_comb begin
        strobe = (state_q == S_BIT) && !frame_pulse;
        synced = (state_q != S_HUNT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos   <= '0;
            wbank <= 1'b0;
        end else if (frame_pulse) begin
            pos   <= '0;
            wbank <= ~wbank;
        end else if (strobe) begin
            pos   <= (pos + 1'b1) & pos_mask;
        end
    end

    a_r2_pos_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pulse |=> (pos == '0));

    a_r2_one_sample_per_pair: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);

    a_r11_bank_flips: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pulse |=> (wbank != $past(wbank)));

endmodule

// File: rtl/tsi_cfg.sv
module tsi_cfg #(
    parameter int NS     = 16,
    parameter int CH_W   = 7,
    parameter int ST_W   = 4,
    parameter int POS_W  = 10,
    parameter int CFG_DW = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic                      cfg_sel,
    input  logic [ST_W+CH_W-1:0]      cfg_addr,
    input  logic [CFG_DW-1:0]         cfg_wdata,
    input  logic [CH_W-1:0]           cur_ch,
    output logic [NS-1:0]             ent_valid,
    output logic [NS-1:0][ST_W-1:0]   ent_st,
    output logic [NS-1:0][CH_W-1:0]   ent_ch,
    output logic [NS-1:0][POS_W-1:0]  offs
);
    localparam int IW      = ST_W + CH_W;
    localparam int ENTRIES = 2 ** IW;

    logic [ENTRIES-1:0]   cvalid;
    logic [IW-1:0]        cmem [ENTRIES];
    logic [NS-1:0][POS_W-1:0] off_q;
    logic [IW-1:0]        widx;
    logic [ST_W-1:0]      wa_st;
    logic                 unused_bits;

    assign widx        = cfg_addr;
    assign wa_st       = cfg_addr[CH_W +: ST_W];
    assign unused_bits = ^cfg_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cvalid <= '0;
            off_q  <= '0;
        end else if (cfg_we) begin
            if (!cfg_sel)                 cvalid[widx] <= 1'b1;
            else if (int'(wa_st) < NS)    off_q[wa_st] <= cfg_wdata[POS_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (cfg_we && !cfg_sel) cmem[widx] <= cfg_wdata[IW-1:0];
    end

    assign offs = off_q;

    for (genvar o = 0; o < NS; o++) begin : g_rd
        logic [IW-1:0] ridx;
        logic [IW-1:0] word;
        assign ridx         = {ST_W'(o), cur_ch};
        assign word         = cmem[ridx];
        assign ent_valid[o] = cvalid[ridx];
        assign ent_st[o]    = word[CH_W +: ST_W];
        assign ent_ch[o]    = word[CH_W-1:0];
    end

    a_r7_entry_marked: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_sel) |=> cvalid[$past(widx)]);

endmodule

// File: rtl/tsi_dmem.sv
module tsi_dmem #(
    parameter int NS     = 16,
    parameter int MAX_CH = 128,
    parameter int CH_W   = 7,
    parameter int ST_W   = 4,
    parameter int POS_W  = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      strobe,
    input  logic                      wbank,
    input  logic [POS_W-1:0]          pos,
    input  logic [POS_W-1:0]          pos_mask,
    input  logic [NS-1:0]             ser_in,
    input  logic [NS-1:0][POS_W-1:0]  offs,
    input  logic [NS-1:0][ST_W-1:0]   rd_st,
    input  logic [NS-1:0][CH_W-1:0]   rd_ch,
    output logic [NS-1:0][7:0]        rd_byte
);
    localparam int SLOTS = 2 ** ST_W;
    localparam int DEPTH = 2 * MAX_CH;

    logic [7:0]               mem [SLOTS][DEPTH];
    logic [NS-1:0][6:0]       sh_q;
    logic [NS-1:0][POS_W-1:0] lp;

    // lane-local bit position after removing the programmed skew
    always_comb begin
        for (int s = 0; s < NS; s++) lp[s] = (pos - offs[s]) & pos_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (strobe) begin
            for (int s = 0; s < NS; s++) sh_q[s] <= {sh_q[s][5:0], ser_in[s]};
        end
    end

    always_ff @(posedge clk) begin
        if (strobe) begin
            for (int s = 0; s < NS; s++) begin
                if (lp[s][2:0] == 3'd7)
                    mem[s][{wbank, lp[s][POS_W-1:3]}] <= {sh_q[s], ser_in[s]};
            end
        end
    end

    always_comb begin
        for (int o = 0; o < NS; o++) rd_byte[o] = mem[rd_st[o]][{~wbank, rd_ch[o]}];
    end

endmodule

// File: rtl/tsi_tx.sv
module tsi_tx #(
    parameter int NS   = 16,
    parameter int CH_W = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    strobe,
    input  logic                    synced,
    input  logic [2:0]              bit_idx,
    input  logic [CH_W:0]           act_ch,
    input  logic [NS-1:0]           ent_valid,
    input  logic [NS-1:0][CH_W-1:0] ent_ch,
    input  logic [NS-1:0][7:0]      rd_byte,
    output logic [NS-1:0]           ser_out
);
    logic [NS-1:0] nxt_bit;

    for (genvar o = 0; o < NS; o++) begin : g_lane
        logic in_range;
        assign in_range   = ({1'b0, ent_ch[o]} < act_ch);
        assign nxt_bit[o] = (ent_valid[o] && in_range) ? rd_byte[o][~bit_idx] : 1'b1;

        a_r8_unwritten_idle: assert property (@(posedge clk) disable iff (!rst_n)
            (strobe && !ent_valid[o]) |=> ser_out[o]);

        a_r9_out_of_range_idle: assert property (@(posedge clk) disable iff (!rst_n)
            (strobe && ent_valid[o] && !in_range) |=> ser_out[o]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ser_out <= '1;
        else if (!synced) ser_out <= '1;
        else if (strobe)  ser_out <= nxt_bit;
    end

    a_r1_high_before_sync: assert property (@(posedge clk) disable iff (!rst_n)
        !synced |-> (&ser_out));

endmodule

// File: rtl/tsi_switch.sv
module tsi_switch #(
    parameter int NSTREAM = 16,
    parameter int BASE_CH = 32
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          frame_pulse,
    input  logic [1:0]                                    rate_sel,
    input  logic [NSTREAM-1:0]                            ser_in,
    output logic [NSTREAM-1:0]                            ser_out,
    input  logic                                          cfg_we,
    input  logic                                          cfg_sel,
    input  logic [$clog2(NSTREAM)+$clog2(BASE_CH*4)-1:0]  cfg_addr,
    input  logic [15:0]                                   cfg_wdata
);
    localparam int MAX_CH = BASE_CH * 4;
    localparam int CH_W   = $clog2(MAX_CH);
    localparam int ST_W   = $clog2(NSTREAM);
    localparam int POS_W  = CH_W + 3;

    logic                          strobe, synced, wbank;
    logic [POS_W-1:0]              pos, pos_mask;
    logic [CH_W:0]                 act_ch;
    logic [NSTREAM-1:0]            ent_valid;
    logic [NSTREAM-1:0][ST_W-1:0]  ent_st;
    logic [NSTREAM-1:0][CH_W-1:0]  ent_ch;
    logic [NSTREAM-1:0][POS_W-1:0] offs;
    logic [NSTREAM-1:0][7:0]       rd_byte;

    tsi_timing #(.BASE_CH(BASE_CH), .CH_W(CH_W), .POS_W(POS_W)) u_timing (
        .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .rate_sel(rate_sel),
        .strobe(strobe), .synced(synced), .wbank(wbank), .pos(pos),
        .pos_mask(pos_mask), .act_ch(act_ch)
    );

    tsi_cfg #(.NS(NSTREAM), .CH_W(CH_W), .ST_W(ST_W), .POS_W(POS_W), .CFG_DW(16)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cur_ch(pos[POS_W-1:3]),
        .ent_valid(ent_valid), .ent_st(ent_st), .ent_ch(ent_ch), .offs(offs)
    );

    tsi_dmem #(.NS(NSTREAM), .MAX_CH(MAX_CH), .CH_W(CH_W), .ST_W(ST_W), .POS_W(POS_W)) u_dmem (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .wbank(wbank), .pos(pos),
        .pos_mask(pos_mask), .ser_in(ser_in), .offs(offs), .rd_st(ent_st),
        .rd_ch(ent_ch), .rd_byte(rd_byte)
    );

    tsi_tx #(.NS(NSTREAM), .CH_W(CH_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .synced(synced),
        .bit_idx(pos[2:0]), .act_ch(act_ch), .ent_valid(ent_valid),
        .ent_ch(ent_ch), .rd_byte(rd_byte), .ser_out(ser_out)
    );

endmodule

// File: tb/tsi_switch_bench.sv
module tsi_switch_bench;
    localparam int NS   = 4;
    localparam int BASE = 4;
    localparam int MAXC = BASE * 4;
    localparam int CH_W = 4;
    localparam int ST_W = 2;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                 rst_n, frame_pulse, cfg_we, cfg_sel;
    logic [1:0]           rate_sel;
    logic [NS-1:0]        ser_in, ser_out;
    logic [ST_W+CH_W-1:0] cfg_addr;
    logic [15:0]          cfg_wdata;

    tsi_switch #(.NSTREAM(NS), .BASE_CH(BASE)) u_tsi_switch (
        .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .rate_sel(rate_sel),
        .ser_in(ser_in), .ser_out(ser_out), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata)
    );

    int n_chk = 0, n_fail = 0, mode = 0;
    bit finished = 0;
    bit m_valid [NS][MAXC];
    int m_st [NS][MAXC];
    int m_ch [NS][MAXC];
    int m_off [NS];
    logic [7:0] cap [NS][MAXC];

    function automatic logic [7:0] in_byte(int s, int c, int t);
        return 8'(s * 53 + c * 29 + t * 71 + 7);
    endfunction

    function automatic int act_of(int m);
        return (m == 1) ? 2 * BASE : (m == 2) ? 4 * BASE : BASE;
    endfunction

    function automatic string mode_tag(int m);
        return (m == 1) ? "R4" : (m == 2) ? "R5" : (m == 3) ? "R6" : "R3";
    endfunction

    task automatic check(string req, logic [7:0] got, logic [7:0] exp, int o, int c);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s out%0d ch%0d actual %h expected %h", req, o, c, got, exp);
        end
    endtask

    task automatic cfg_write(bit sel, int a_st, int a_ch, int data);
        cfg_we    = 1'b1;
        cfg_sel   = sel;
        cfg_addr  = {ST_W'(a_st), CH_W'(a_ch)};
        cfg_wdata = 16'(data);
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic connect(int o, int c, int st, int ch);
        m_valid[o][c] = 1'b1; m_st[o][c] = st; m_ch[o][c] = ch;
        cfg_write(1'b0, o, c, (st << CH_W) | ch);   // R7 field layout
    endtask

    task automatic set_off(int s, int v);
        m_off[s] = v;
        cfg_write(1'b1, s, 0, v);                    // R10 offset write
    endtask

    task automatic program_map();
        int act = act_of(mode);
        for (int o = 0; o < NS; o++)
            for (int c = 0; c < act; c++) begin
                if (o == 0 && c == 1) continue;
                if (o == 1 && c == 2 && act < MAXC) connect(o, c, (o + c + 1) % NS, act + 3);
                else connect(o, c, (o + c + 1) % NS, (3 * c + o) % act);
            end
    endtask

    task automatic run_frame(int t);
        int fb = act_of(mode) * 8;
        rate_sel    = 2'(mode);
        frame_pulse = 1'b1;
        @(negedge clk);
        frame_pulse = 1'b0;
        for (int j = 0; j < fb; j++) begin
            for (int s = 0; s < NS; s++) begin
                int lp = (((j - (m_off[s] % fb)) % fb) + fb) % fb;
                logic [7:0] b = in_byte(s, lp / 8, t);
                ser_in[s] = b[7 - (lp % 8)];
            end
            @(negedge clk);
            for (int o = 0; o < NS; o++) cap[o][j / 8][7 - (j % 8)] = ser_out[o];
            if (j < fb - 1) @(negedge clk);
        end
    endtask

    task automatic check_frame(int texp, string extra);
        int act = act_of(mode);
        for (int o = 0; o < NS; o++)
            for (int c = 0; c < act; c++) begin
                logic [7:0] exp;
                string lbl;
                if (!m_valid[o][c]) begin exp = 8'hFF; lbl = "R8"; end
                else if (m_ch[o][c] >= act) begin exp = 8'hFF; lbl = "R9"; end
                else begin
                    exp = in_byte(m_st[o][c], m_ch[o][c], texp);
                    lbl = {mode_tag(mode), " R2 R7", extra};
                end
                check(lbl, cap[o][c], exp, o, c);
            end
    endtask

    task automatic settle_and_check(int t, string extra);
        run_frame(t); run_frame(t); run_frame(t);
        check_frame(t, extra);
    endtask

    initial begin
        rst_n = 1'b0; frame_pulse = 1'b0; cfg_we = 1'b0; cfg_sel = 1'b0;
        cfg_addr = '0; cfg_wdata = '0; rate_sel = 2'b00; ser_in = '0;
        for (int s = 0; s < NS; s++) m_off[s] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: no frame pulse yet, lanes high whatever the inputs do
        for (int k = 0; k < 6; k++) begin
            ser_in = 4'(k * 5);
            @(negedge clk);
            check("R1", {4'h0, ser_out}, 8'h0F, 0, k);
        end
        // R8: nothing programmed
        mode = 0;
        settle_and_check(0, "");
        // R3, R7, R8, R9
        program_map();
        settle_and_check(1, "");
        // R11: new content is seen one frame late
        run_frame(2);
        check_frame(1, " R11");
        run_frame(2);
        check_frame(2, " R11");
        // R10: skewed lanes, one offset beyond the frame length
        set_off(0, 3); set_off(1, 9); set_off(2, 37); set_off(3, 31);
        settle_and_check(3, " R10");
        // R4
        mode = 1;
        program_map();
        settle_and_check(4, " R10");
        // R5
        mode = 2;
        program_map();
        settle_and_check(5, " R10");
        // R6: code 11 acts as base rate, mode-2 entries partly out of range
        mode = 3;
        settle_and_check(6, " R10");
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog R2 actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule